// File: doc/BRIEF.md
# Up/Down Event Counter with Capture Register

This block counts events into a 32-bit accumulator. It takes its events from one of two input schemes. In step/direction form, each rising edge on the step input moves the count by one, and the level of the direction input selects up or down. In two-phase form, the same two pins carry a pair of quadrature signals. Every valid transition of either phase moves the count by one, and the phase order selects the direction.

Software or surrounding logic steers the counter with four level controls. Clear holds the count at zero. Preset holds it at a supplied value, and counting resumes from that value once preset is released. An enable gates the counting. A capture control copies the running count into a separate register on its rising edge, without disturbing the count. A mode pin picks between a plain level enable and a one-shot form. In the one-shot form, a rising edge on enable arms counting, the counter stays armed after enable falls, and clear disarms it.

All inputs are asynchronous to the system clock. Each input passes through a two-stage synchroniser, and the block detects edges after synchronisation. The two mode pins are treated as static configuration.

Top module: `evt_counter`

## Requirements
- R1: With `quad_mode` low, each rising edge of `cnt_a` adds one to `count_q` when `cnt_b` is high and subtracts one when `cnt_b` is low.
- R2: While `ctl_preset` is high (and `ctl_clear` low), `count_q` equals `preset_val` and ignores count edges. After `ctl_preset` falls, counting continues from that value.
- R3: While `ctl_clear` is high, `count_q` is zero and ignores count edges, even when `ctl_preset` is also high. Counting resumes from zero after release.
- R4: A rising edge of `ctl_capture` copies `count_q` into `capture_q`. `capture_q` keeps that value until the next rising edge, including while `ctl_capture` stays high, and counting goes on undisturbed.
- R5: With `oneshot_mode` low, a low `ctl_enable` blocks all counting.
- R6: With `oneshot_mode` high, counting is blocked until a rising edge of `ctl_enable`, and continues after `ctl_enable` falls. A high `ctl_clear` zeroes the count and disarms counting until the next enable rising edge.
- R7: With `quad_mode` high, the phase sequence (A,B) = 00, 10, 11, 01, 00 adds one per transition, and the reverse sequence subtracts one per transition.
- R8: With `quad_mode` high, a transition where both phases change in the same sample leaves `count_q` unchanged.
- R9: `count_q` wraps modulo 2^32: one step up from all ones gives zero, and one step down from zero gives all ones.
- R10: After reset, `count_q` and `capture_q` are zero and the one-shot enable is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_a | input | 1 | Step input, or quadrature phase A |
| cnt_b | input | 1 | Direction input (high = up), or quadrature phase B |
| quad_mode | input | 1 | 0 = step/direction, 1 = quadrature 4x |
| oneshot_mode | input | 1 | 0 = level enable, 1 = edge-armed sticky enable |
| ctl_preset | input | 1 | Level preset to `preset_val` |
| ctl_clear | input | 1 | Level clear to zero; highest priority |
| ctl_enable | input | 1 | Count enable |
| ctl_capture | input | 1 | Capture count on rising edge |
| preset_val | input | 32 | Value loaded while preset is held |
| count_q | output | 32 | Live accumulator |
| capture_q | output | 32 | Captured count |

## Verification
The assertions assume that `preset_val` holds steady while preset is active, since it is sampled directly without synchronisation. They also assume that the two mode pins change only while the count inputs are idle. The stimulus changes inputs only on falling clock edges and holds every level for several cycles, so each change crosses the synchroniser cleanly. It changes the mode pins only with both count inputs low, and it applies each quadrature step as a single-phase change, except in the deliberate double-change case.

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int W = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_a,
  input  logic         cnt_b,
  input  logic         quad_mode,
  input  logic         oneshot_mode,
  input  logic         ctl_preset,
  input  logic         ctl_clear,
  input  logic         ctl_enable,
  input  logic         ctl_capture,
  input  logic [W-1:0] preset_val,
  output logic [W-1:0] count_q,
  output logic [W-1:0] capture_q
);
  localparam int NIN = 6;

  logic [NIN-1:0] raw, s, prev_q;
  logic [NIN-1:0] sync_q [SYNC_STAGES];
  logic           run_q;

  assign raw = {ctl_capture, ctl_enable, ctl_clear, ctl_preset, cnt_b, cnt_a};
  assign s   = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= s;
    end
  end

  wire a_s = s[0], b_s = s[1], pre_s = s[2], clr_s = s[3], en_s = s[4], cap_s = s[5];
  wire a_p = prev_q[0], b_p = prev_q[1];

  wire en_rise  = en_s & ~prev_q[4];
  wire cap_rise = cap_s & ~prev_q[5];
  wire q_step   = (a_s ^ a_p) ^ (b_s ^ b_p);
  wire step     = quad_mode ? q_step : (a_s & ~a_p);
  wire up       = quad_mode ? (a_s ^ b_p) : b_s;
  wire run      = oneshot_mode ? run_q : en_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= 1'b0;
    else if (clr_s)   run_q <= 1'b0;
    else if (en_rise) run_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             count_q <= '0;
    else if (clr_s)         count_q <= '0;
    else if (pre_s)         count_q <= preset_val;
    else if (run && step)   count_q <= up ? count_q + W'(1) : count_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        capture_q <= '0;
    else if (cap_rise) capture_q <= count_q;
  end

  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> count_q == '0);
  a_r2_preset_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_s && !clr_s) |=> count_q == $past(preset_val));
  a_r4_capture_take: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rise |=> capture_q == $past(count_q));
  a_r4_capture_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_rise |=> $stable(capture_q));
  a_r5_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (!oneshot_mode && !en_s && !clr_s && !pre_s) |=> $stable(count_q));
  a_r6_clear_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> !run_q);
  a_r9_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && !pre_s) |=> (count_q == $past(count_q) ||
                            count_q == $past(count_q) + W'(1) ||
                            count_q == $past(count_q) - W'(1)));
  a_r8_double_change: assert property (@(posedge clk) disable iff (!rst_n)
    (quad_mode && (a_s != a_p) && (b_s != b_p) && !clr_s && !pre_s) |=> $stable(count_q));
endmodule

// File: tb/evt_counter_tb_top.sv
module evt_counter_tb_top;
  logic clk = 0, rst_n = 0;
  logic cnt_a = 0, cnt_b = 0, quad_mode = 0, oneshot_mode = 0;
  logic ctl_preset = 0, ctl_clear = 0, ctl_enable = 0, ctl_capture = 0;
  logic [31:0] preset_val = 0;
  logic [31:0] count_q, capture_q;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  evt_counter dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_a(cnt_a), .cnt_b(cnt_b),
    .quad_mode(quad_mode), .oneshot_mode(oneshot_mode),
    .ctl_preset(ctl_preset), .ctl_clear(ctl_clear), .ctl_enable(ctl_enable),
    .ctl_capture(ctl_capture), .preset_val(preset_val),
    .count_q(count_q), .capture_q(capture_q));

  task automatic settle(); repeat (5) @(negedge clk); endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      cnt_a = 1; settle(); cnt_a = 0; settle();
    end
  endtask

  task automatic qstep(input logic a, input logic b);
    cnt_a = a; cnt_b = b; settle();
  endtask

  task automatic t_reset();
    rst_n = 0; repeat (4) @(negedge clk);
    check("R10 count", count_q, 0);
    check("R10 capture", capture_q, 0);
    rst_n = 1; settle();
  endtask

  task automatic t_step_dir();
    ctl_enable = 1; cnt_b = 1; settle();
    pulse(5); check("R1 up", count_q, 5);
    cnt_b = 0; settle(); pulse(2); check("R1 down", count_q, 3);
  endtask

  task automatic t_enable();
    ctl_enable = 0; settle(); cnt_b = 1; pulse(3);
    check("R5 inhibit", count_q, 3);
    ctl_enable = 1; settle();
  endtask

  task automatic t_preset();
    preset_val = 100; ctl_preset = 1; settle();
    check("R2 forced", count_q, 100);
    pulse(2); check("R2 held", count_q, 100);
    ctl_preset = 0; settle(); pulse(2);
    check("R2 resume", count_q, 102);
  endtask

  task automatic t_clear();
    ctl_clear = 1; ctl_preset = 1; settle();
    check("R3 priority", count_q, 0);
    pulse(2); check("R3 held", count_q, 0);
    ctl_clear = 0; ctl_preset = 0; settle(); pulse(1);
    check("R3 resume", count_q, 1);
  endtask

  task automatic t_capture();
    ctl_capture = 1; settle();
    check("R4 take", capture_q, 1);
    pulse(3);
    check("R4 count undisturbed", count_q, 4);
    check("R4 keep", capture_q, 1);
    ctl_capture = 0; settle(); ctl_capture = 1; settle();
    check("R4 retake", capture_q, 4);
    ctl_capture = 0; settle();
  endtask

  task automatic t_wrap();
    preset_val = 32'hFFFF_FFFF; ctl_preset = 1; settle(); ctl_preset = 0; settle();
    cnt_b = 1; settle(); pulse(1); check("R9 up wrap", count_q, 0);
    cnt_b = 0; settle(); pulse(1); check("R9 down wrap", count_q, 32'hFFFF_FFFF);
  endtask

  task automatic t_oneshot();
    ctl_enable = 0; oneshot_mode = 1; cnt_b = 1;
    ctl_clear = 1; settle(); ctl_clear = 0; settle();
    pulse(2); check("R6 disarmed", count_q, 0);
    ctl_enable = 1; settle(); ctl_enable = 0; settle();
    pulse(3); check("R6 sticky", count_q, 3);
    ctl_clear = 1; settle(); check("R6 clear zero", count_q, 0);
    ctl_clear = 0; settle(); pulse(2);
    check("R6 clear disarms", count_q, 0);
    oneshot_mode = 0; ctl_enable = 1; settle();
  endtask

  task automatic t_quad();
    cnt_a = 0; cnt_b = 0; settle(); quad_mode = 1; settle();
    qstep(1, 0); qstep(1, 1); qstep(0, 1); qstep(0, 0);
    check("R7 up", count_q, 4);
    qstep(0, 1); qstep(1, 1); qstep(1, 0); qstep(0, 0);
    check("R7 down", count_q, 0);
    qstep(1, 1); check("R8 double change", count_q, 0);
    qstep(0, 0); check("R8 double change back", count_q, 0);
  endtask

  initial begin
    t_reset();
    t_step_dir();
    t_enable();
    t_preset();
    t_clear();
    t_capture();
    t_wrap();
    t_oneshot();
    t_quad();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule